// File: doc/BRIEF.md
# Programmable Propagate/Generate ALU

This block is an n-bit arithmetic and logic unit built around a single carry-propagate adder. A programmable propagate unit turns each operand bit pair into any two-input Boolean function, chosen by a four-bit truth-table word. A generate unit supplies the carry-creating term for the current operation. A ripple carry chain combines the two terms, and each result bit is the propagate term XOR the carry that reaches it. Logic operations pass through the same adder: generate and the carry-in are forced to zero, so each result bit equals its propagate term.

Subtraction uses no separate operand inverter. Only the propagate and generate definitions change, and the carry-in is forced to one, which gives A + NOT B + 1. Because the combinational sum settles late and only holds while the operands are stable, a register captures the result and carry-out whenever `start` is sampled high. A valid flag marks the cycle that follows each capture.

Top module: `alu_pg`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `result`, `cout` and `valid` to zero.
- R2: With `op` = 2'b00 (add), a capture loads `{cout, result}` with `a + b + cin`, computed over WIDTH+1 bits.
- R3: With `op` = 2'b01 (subtract), a capture loads `result` with `a - b` modulo 2^WIDTH and `cout` with 1 exactly when `a >= b` (unsigned). `cin` has no effect.
- R4: With `op` = 2'b10 (logic), result bit i is `tt[{a[i], b[i]}]`, so `tt[0]` applies to the pair (0,0), `tt[1]` to (0,1), `tt[2]` to (1,0) and `tt[3]` to (1,1). XOR is 4'b0110, AND is 4'b1000 and OR is 4'b1110. `cout` is 0 and `cin` has no effect.
- R5: With `op` = 2'b11 (pass), `result` equals `a` and `cout` is 0. `tt`, `b` and `cin` have no effect.
- R6: A rising edge with `start` low leaves `result` and `cout` unchanged, whatever the operands are.
- R7: `valid` is 1 in the cycle after an edge where `start` was high (and reset was low), and 0 after an edge where `start` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture the current result at this edge |
| op | input | 2 | Operation: 00 add, 01 subtract, 10 logic, 11 pass A |
| tt | input | 4 | Truth-table word for logic mode, bit k selected by {a_i, b_i} |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in, used by add only |
| result | output | WIDTH | Registered result |
| cout | output | 1 | Registered carry-out (for subtract: no borrow) |
| valid | output | 1 | Result was captured at the previous edge |

## Verification
All sixteen truth-table words are run on operand pairs that contain every (a,b) bit combination. This exposes a swapped index, an inverted entry or a generate term that leaks into logic mode. Addition is tried with full carry ripples (all ones plus one), with both carry-in values and with random operands. These cases separate the external carry from the forced one and show whether the carry chain links every stage. Subtraction is tried with equal operands, with borrows (a < b), with a zero subtrahend and with both carry-in values, which shows that the forced carry-in and the redefined propagate and generate terms produce the correct borrow flag. Idle cycles with changing operands show that the register holds and that the valid flag drops.

// File: rtl/alu_pg_pkg.sv
package alu_pg_pkg;

    typedef enum logic [1:0] {
        OP_ADD   = 2'b00,
        OP_SUB   = 2'b01,
        OP_LOGIC = 2'b10,
        OP_PASSA = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        GEN_AND  = 2'b00,
        GEN_ANDN = 2'b01,
        GEN_ZERO = 2'b10
    } gen_sel_e;

    // Truth table that returns the first operand bit
    localparam logic [3:0] TT_PASS_A = 4'b1100;
    // Truth tables used for arithmetic
    localparam logic [3:0] TT_XOR    = 4'b0110;
    localparam logic [3:0] TT_XNOR   = 4'b1001;

endpackage

// File: rtl/alu_pg_ctrl.sv
module alu_pg_ctrl
    import alu_pg_pkg::*;
(
    input  logic [1:0] op,
    input  logic [3:0] tt,
    input  logic       cin,
    output logic [3:0] prop_tt,
    output gen_sel_e   gen_sel,
    output logic       carry_in
);

    always_comb begin
        prop_tt  = TT_XOR;
        gen_sel  = GEN_AND;
        carry_in = cin;
        unique case (alu_op_e'(op))
            OP_ADD: begin
                prop_tt  = TT_XOR;
                gen_sel  = GEN_AND;
                carry_in = cin;
            end
            OP_SUB: begin
                prop_tt  = TT_XNOR;
                gen_sel  = GEN_ANDN;
                carry_in = 1'b1;
            end
            OP_LOGIC: begin
                prop_tt  = tt;
                gen_sel  = GEN_ZERO;
                carry_in = 1'b0;
            end
            OP_PASSA: begin
                prop_tt  = TT_PASS_A;
                gen_sel  = GEN_ZERO;
                carry_in = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_pg_terms.sv
module alu_pg_terms
    import alu_pg_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       prop_tt,
    input  gen_sel_e         gen_sel,
    output logic [WIDTH-1:0] prop,
    output logic [WIDTH-1:0] gen
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [1:0] pair;
        assign pair = {a[i], b[i]};

        always_comb begin
            prop[i] = prop_tt[pair];
            unique case (gen_sel)
                GEN_AND:  gen[i] = a[i] & b[i];
                GEN_ANDN: gen[i] = a[i] & ~b[i];
                default:  gen[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/alu_pg_carry.sv
module alu_pg_carry #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] gen,
    input  logic             carry_in,
    output logic [WIDTH-1:0] carry_at,
    output logic             carry_out
);

    logic [WIDTH:0] chain;

    assign chain[0] = carry_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        assign chain[i+1] = gen[i] | (prop[i] & chain[i]);
    end

    assign carry_at  = chain[WIDTH-1:0];
    assign carry_out = chain[WIDTH];

endmodule

// File: rtl/alu_pg.sv
module alu_pg
    import alu_pg_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [3:0]       tt,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] result,
    output logic             cout,
    output logic             valid
);

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             co;
        logic             vld;
    } out_state_t;

    logic [3:0]       prop_tt;
    gen_sel_e         gen_sel;
    logic             carry_in;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] carry_at;
    logic             carry_out;
    logic [WIDTH-1:0] raw_sum;

    out_state_t st_d, st_q;

    alu_pg_ctrl u_ctrl (
        .op       (op),
        .tt       (tt),
        .cin      (cin),
        .prop_tt  (prop_tt),
        .gen_sel  (gen_sel),
        .carry_in (carry_in)
    );

    alu_pg_terms #(.WIDTH(WIDTH)) u_terms (
        .a       (a),
        .b       (b),
        .prop_tt (prop_tt),
        .gen_sel (gen_sel),
        .prop    (prop),
        .gen     (gen)
    );

    alu_pg_carry #(.WIDTH(WIDTH)) u_carry (
        .prop      (prop),
        .gen       (gen),
        .carry_in  (carry_in),
        .carry_at  (carry_at),
        .carry_out (carry_out)
    );

    assign raw_sum = prop ^ carry_at;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (start) begin
            st_d.res = raw_sum;
            st_d.co  = carry_out;
            st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.res;
    assign cout   = st_q.co;
    assign valid  = st_q.vld;

endmodule

// File: rtl/alu_pg_chk.sv
module alu_pg_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [1:0]       op,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] result,
    input logic             cout,
    input logic             valid
);

    logic [WIDTH:0] add_ref;
    logic [WIDTH:0] sub_ref;

    assign add_ref = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    assign sub_ref = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (result == '0 && !cout && !valid));                      // R1

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'b00) |=> ({cout, result} == $past(add_ref)));  // R2

    AST_SUB_DIFF: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'b01) |=> ({cout, result} == $past(sub_ref)));  // R3

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (start && op[1]) |=> !cout);                                     // R4

    AST_PASS_A: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'b11) |=> (result == $past(a)));                // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(result) && $stable(cout)));                  // R6

    AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
        start |=> valid);                                                // R7

    AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !start |=> !valid);                                              // R7

endmodule

bind alu_pg alu_pg_chk #(.WIDTH(WIDTH)) u_alu_pg_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op     (op),
    .a      (a),
    .b      (b),
    .cin    (cin),
    .result (result),
    .cout   (cout),
    .valid  (valid)
);

// File: tb/tb_alu_pg.sv
module tb_alu_pg;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [1:0]   op;
    logic [3:0]   tt;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    logic [W-1:0] result;
    logic         cout;
    logic         valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5ns clk = ~clk;

    alu_pg #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .tt(tt),
        .a(a), .b(b), .cin(cin), .result(result), .cout(cout), .valid(valid)
    );

    task automatic check(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, capture it at the next rising edge,
    // sample at the following falling edge.
    task automatic run_op(input logic [1:0] o, input logic [3:0] t,
                          input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        @(negedge clk);
        op = o; tt = t; a = x; b = y; cin = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic logic [W-1:0] logic_ref(input logic [3:0] t,
                                               input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = t[{x[i], y[i]}];
        return r;
    endfunction

    task automatic test_reset();
        rst = 1'b1; start = 1'b0; op = 2'b00; tt = 4'h0; a = '0; b = '0; cin = 1'b0;
        repeat (3) @(negedge clk);
        // R1: all registered outputs cleared
        check("R1 reset result", {2'b00, result}, '0);
        check("R1 reset cout",   {{(W+1){1'b0}}, cout}, '0);
        check("R1 reset valid",  {{(W+1){1'b0}}, valid}, '0);
        rst = 1'b0;
    endtask

    task automatic do_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        logic [W:0] exp;
        exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        run_op(2'b00, 4'h0, x, y, c);
        check("R2 add", {1'b0, cout, result}, {1'b0, exp});
        check("R7 valid after add", {{(W+1){1'b0}}, valid}, 1);
    endtask

    task automatic test_add();
        do_add('1, 16'h0001, 1'b0);
        do_add('1, '0, 1'b1);
        do_add('1, '1, 1'b1);
        do_add(16'h1234, 16'h4321, 1'b0);
        for (int k = 0; k < 20; k++) do_add(W'($urandom), W'($urandom), 1'($urandom));
    endtask

    task automatic do_sub(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        logic [W-1:0] d;
        logic         nb;
        d  = x - y;
        nb = (x >= y);
        run_op(2'b01, 4'h0, x, y, c);
        check("R3 sub diff",   {2'b00, result}, {2'b00, d});
        check("R3 sub borrow", {{(W+1){1'b0}}, cout}, {{(W+1){1'b0}}, nb});
    endtask

    task automatic test_sub();
        do_sub(16'h0005, 16'h0005, 1'b0);
        do_sub(16'h0003, 16'h0007, 1'b0);
        do_sub(16'h0003, 16'h0007, 1'b1);
        do_sub('0, 16'h0001, 1'b1);
        do_sub(16'h8000, '0, 1'b0);
        do_sub(16'hFFFF, 16'hFFFE, 1'b1);
        for (int k = 0; k < 20; k++) do_sub(W'($urandom), W'($urandom), 1'($urandom));
    endtask

    task automatic test_logic();
        // a/b patterns covering every bit pair in every nibble
        logic [W-1:0] xa [3];
        logic [W-1:0] xb [3];
        xa[0] = 16'hCCCC; xb[0] = 16'hAAAA;
        xa[1] = 16'hF0F0; xb[1] = 16'hFF00;
        xa[2] = 16'h5A3C; xb[2] = 16'h96E1;
        for (int t = 0; t < 16; t++) begin
            for (int p = 0; p < 3; p++) begin
                run_op(2'b10, 4'(t), xa[p], xb[p], 1'(p & 1));
                check("R4 logic result", {2'b00, result}, {2'b00, logic_ref(4'(t), xa[p], xb[p])});
                check("R4 logic cout",   {{(W+1){1'b0}}, cout}, '0);
            end
        end
    endtask

    task automatic test_pass();
        for (int k = 0; k < 6; k++) begin
            logic [W-1:0] x;
            x = W'($urandom);
            run_op(2'b11, 4'($urandom), x, W'($urandom), 1'(k & 1));
            check("R5 pass result", {2'b00, result}, {2'b00, x});
            check("R5 pass cout",   {{(W+1){1'b0}}, cout}, '0);
        end
    endtask

    task automatic test_idle();
        logic [W-1:0] held;
        logic         hco;
        run_op(2'b00, 4'h0, '1, 16'h0001, 1'b0);   // result 0, cout 1
        held = result; hco = cout;
        op = 2'b01; a = 16'h0042; b = 16'h0100; cin = 1'b1;
        @(negedge clk);
        check("R7 valid low when idle", {{(W+1){1'b0}}, valid}, '0);
        a = 16'h7777; op = 2'b11;
        @(negedge clk);
        check("R6 idle result hold", {2'b00, result}, {2'b00, held});
        check("R6 idle cout hold",   {{(W+1){1'b0}}, cout}, {{(W+1){1'b0}}, hco});
        check("R6 expected held value", {1'b0, hco, held}, {1'b0, 1'b1, {W{1'b0}}});
    endtask

    initial begin
        test_reset();
        test_add();
        test_sub();
        test_logic();
        test_pass();
        test_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule